// File: doc/BRIEF.md
# Dual-Port Shared-Location Busy Arbiter

This block sits beside a memory shared by two independent access ports, called left and right. Every cycle it compares the enable and address that each port presents. When both ports are enabled on the same location, one port keeps the location and the other is flagged busy. The flagged port's write strobe is suppressed inside the block, so only the qualified strobes go on to the storage array. Reads on a flagged port still go ahead, but they carry a marker that the returned data cannot be trusted.

In master mode the block makes the decision itself and drives two active-low busy outputs. A port that has been holding the location since the previous clock keeps it. When both ports reach the location in the same cycle, the left port wins. In slave mode the block makes no decision. Each port's active-low busy input acts only as a write inhibit for that port, so several slave devices can follow a single master's decision.

The block is fully synchronous to one clock. Its qualified outputs follow the current inputs combinationally. The only state is a one-cycle history of each port and a record of which port currently owns the contended location.

Top module: `dpbusy_arbiter`

## Requirements
- R1: In master mode, both busy outputs (active low, 1 = inactive) stay 1 unless both enables (active high) are 1 and the two addresses are equal.
- R2: In master mode, when a match begins, a port whose enable was 1 with the same address on the previous clock keeps the location, and the newly arrived port gets busy. That decision holds for as long as the match lasts.
- R3: The two busy outputs are never 0 in the same cycle.
- R4: When a match begins with neither port, or both ports, already holding that address, the right port gets busy. This includes the first cycle after reset and the cycle after leaving slave mode.
- R5: Arbitration depends only on enable and address. The same contention gives the same busy result whether the write strobes are 0 (reads) or 1 (writes).
- R6: In master mode, a qualified write (enable and write strobe both 1) is issued only when that port is not flagged busy. The busy inputs have no effect in master mode.
- R7: In slave mode, both busy outputs are 1 and nothing is arbitrated. A busy input at 0 blocks that port's writes. A busy input at 1 lets writes through, even when the addresses match.
- R8: A read (enable 1, write strobe 0) on a port whose effective busy is active raises that port's read-suspect output. Other reads do not raise it.
- R9: Busy is released in the same cycle that the addresses stop matching or either enable goes to 0.
- R10: While reset is asserted (rstN = 0), the busy outputs are 1 and the qualified writes and read-suspect outputs are 0. The port history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slaveMode | input | 1 | 1 = busy pins act as write-inhibit inputs; 0 = block arbitrates |
| leftEn | input | 1 | Left port enable, active high |
| leftAddr | input | ADDR_W | Left port address |
| leftWe | input | 1 | Left port write strobe, active high |
| leftBusyInN | input | 1 | Left write inhibit, active low, used in slave mode |
| rightEn | input | 1 | Right port enable, active high |
| rightAddr | input | ADDR_W | Right port address |
| rightWe | input | 1 | Right port write strobe, active high |
| rightBusyInN | input | 1 | Right write inhibit, active low, used in slave mode |
| leftBusyOutN | output | 1 | Left busy flag, active low |
| rightBusyOutN | output | 1 | Right busy flag, active low |
| leftWeGated | output | 1 | Qualified left write strobe |
| rightWeGated | output | 1 | Qualified right write strobe |
| leftRdSuspect | output | 1 | Left read data not guaranteed |
| rightRdSuspect | output | 1 | Right read data not guaranteed |

## Verification
Every output is a combinational function of the current inputs and of state captured at the previous rising edge, so each result is due in the same cycle as its stimulus. The bench therefore drives inputs on the falling edge and samples a quarter period later, before the next rising edge. Who arrived first is decided by the history captured at the rising edge between two vectors. Each table row therefore sets up the history for the row after it, and the order of the rows is part of the test.

// File: rtl/dpbusy_pkg.sv
package dpbusy_pkg;

  // Which port currently owns a contended location
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } ownerT;

  // Strobes from control to datapath
  typedef struct packed {
    logic leftLoses;
    logic rightLoses;
  } arbStrobeT;

  // Comparison status from datapath to control
  typedef struct packed {
    logic match;
    logic leftHeld;
    logic rightHeld;
  } cmpStatusT;

endpackage

// File: rtl/dpbusy_side.sv
module dpbusy_side #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              busyInN,
  input  logic              loses,
  output logic              held,
  output logic              weGated,
  output logic              busyOutN,
  output logic              rdSuspect
);

  logic              prevEn;
  logic [ADDR_W-1:0] prevAddr;
  logic              effBusy;

  // One-cycle history of this port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevEn   <= 1'b0;
      prevAddr <= '0;
    end else begin
      prevEn   <= en;
      prevAddr <= addr;
    end
  end

  always_comb begin
    held      = en && prevEn && (addr == prevAddr);
    effBusy   = slaveMode ? !busyInN : loses;
    weGated   = rstN && en && we && !effBusy;
    busyOutN  = !(rstN && !slaveMode && loses);
    rdSuspect = rstN && en && !we && effBusy;
  end

  // R6
  master_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && loses) |-> !weGated);

  // R7
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    slaveMode |-> busyOutN);

  // R7
  slave_inhibit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slaveMode && !busyInN) |-> !weGated);

  // R8
  suspect_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && !we && !busyOutN) |-> rdSuspect);

endmodule

// File: rtl/dpbusy_datapath.sv
module dpbusy_datapath
  import dpbusy_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWe,
  input  logic              leftBusyInN,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWe,
  input  logic              rightBusyInN,
  input  arbStrobeT         strobe,
  output cmpStatusT         status,
  output logic              leftBusyOutN,
  output logic              rightBusyOutN,
  output logic              leftWeGated,
  output logic              rightWeGated,
  output logic              leftRdSuspect,
  output logic              rightRdSuspect
);

  logic leftHeld;
  logic rightHeld;

  dpbusy_side #(.ADDR_W(ADDR_W)) leftSide (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .en(leftEn), .addr(leftAddr), .we(leftWe), .busyInN(leftBusyInN),
    .loses(strobe.leftLoses), .held(leftHeld), .weGated(leftWeGated),
    .busyOutN(leftBusyOutN), .rdSuspect(leftRdSuspect)
  );

  dpbusy_side #(.ADDR_W(ADDR_W)) rightSide (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .en(rightEn), .addr(rightAddr), .we(rightWe), .busyInN(rightBusyInN),
    .loses(strobe.rightLoses), .held(rightHeld), .weGated(rightWeGated),
    .busyOutN(rightBusyOutN), .rdSuspect(rightRdSuspect)
  );

  always_comb begin
    status.match     = leftEn && rightEn && (leftAddr == rightAddr);
    status.leftHeld  = leftHeld;
    status.rightHeld = rightHeld;
  end

  // R1
  no_match_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(leftEn && rightEn && (leftAddr == rightAddr))) |-> (leftBusyOutN && rightBusyOutN));

endmodule

// File: rtl/dpbusy_ctrl.sv
module dpbusy_ctrl
  import dpbusy_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      slaveMode,
  input  cmpStatusT status,
  output arbStrobeT strobe
);

  ownerT owner;
  ownerT ownerNext;

  always_comb begin
    strobe    = '0;
    ownerNext = OWN_NONE;
    if (rstN && !slaveMode && status.match) begin
      unique case (owner)
        OWN_LEFT: begin
          strobe.rightLoses = 1'b1;
          ownerNext         = OWN_LEFT;
        end
        OWN_RIGHT: begin
          strobe.leftLoses = 1'b1;
          ownerNext        = OWN_RIGHT;
        end
        default: begin
          if (status.rightHeld && !status.leftHeld) begin
            strobe.leftLoses = 1'b1;
            ownerNext        = OWN_RIGHT;
          end else begin
            strobe.rightLoses = 1'b1;
            ownerNext         = OWN_LEFT;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owner <= OWN_NONE;
    else       owner <= ownerNext;
  end

  // R3
  one_loser_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.leftLoses && strobe.rightLoses));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !status.match |-> (!strobe.leftLoses && !strobe.rightLoses));

  // R2
  keep_right_loser_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.rightLoses) && status.match && !slaveMode) |-> strobe.rightLoses);

  // R2
  keep_left_loser_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.leftLoses) && status.match && !slaveMode) |-> strobe.leftLoses);

  // R4
  tie_right_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && status.match && !$past(status.match) &&
     (status.leftHeld == status.rightHeld)) |-> strobe.rightLoses);

endmodule

// File: rtl/dpbusy_arbiter.sv
module dpbusy_arbiter
  import dpbusy_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWe,
  input  logic              leftBusyInN,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWe,
  input  logic              rightBusyInN,
  output logic              leftBusyOutN,
  output logic              rightBusyOutN,
  output logic              leftWeGated,
  output logic              rightWeGated,
  output logic              leftRdSuspect,
  output logic              rightRdSuspect
);

  arbStrobeT strobe;
  cmpStatusT status;

  dpbusy_datapath #(.ADDR_W(ADDR_W)) datapath (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .leftEn(leftEn), .leftAddr(leftAddr), .leftWe(leftWe), .leftBusyInN(leftBusyInN),
    .rightEn(rightEn), .rightAddr(rightAddr), .rightWe(rightWe), .rightBusyInN(rightBusyInN),
    .strobe(strobe), .status(status),
    .leftBusyOutN(leftBusyOutN), .rightBusyOutN(rightBusyOutN),
    .leftWeGated(leftWeGated), .rightWeGated(rightWeGated),
    .leftRdSuspect(leftRdSuspect), .rightRdSuspect(rightRdSuspect)
  );

  dpbusy_ctrl control (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .status(status), .strobe(strobe)
  );

endmodule

// File: tb/dpbusy_arbiter_test.sv
module dpbusy_arbiter_test;

  localparam int AW = 10;
  localparam int NVEC = 20;

  // Expected bits: [5] leftBusyOutN [4] rightBusyOutN [3] leftWeGated
  //                [2] rightWeGated [1] leftRdSuspect [0] rightRdSuspect
  typedef struct packed {
    logic          slv;
    logic          lEn;
    logic [AW-1:0] lAddr;
    logic          lWe;
    logic          lBin;
    logic          rEn;
    logic [AW-1:0] rAddr;
    logic          rWe;
    logic          rBin;
    logic [5:0]    expv;
  } vecT;

  // Each row is one cycle; history comes from the row before it
  localparam vecT VECS [NVEC] = '{
    '{1'b0, 1'b0, 10'd0, 1'b0, 1'b1, 1'b0, 10'd0, 1'b0, 1'b1, 6'b110000}, // R1 idle
    '{1'b0, 1'b1, 10'd5, 1'b1, 1'b1, 1'b0, 10'd0, 1'b0, 1'b1, 6'b111000}, // R1 one port only
    '{1'b0, 1'b1, 10'd5, 1'b1, 1'b1, 1'b1, 10'd5, 1'b0, 1'b1, 6'b101001}, // R2 R8 right arrives late
    '{1'b0, 1'b1, 10'd5, 1'b1, 1'b1, 1'b1, 10'd5, 1'b1, 1'b1, 6'b101000}, // R6 loser write gated
    '{1'b0, 1'b0, 10'd5, 1'b1, 1'b1, 1'b1, 10'd5, 1'b1, 1'b1, 6'b110100}, // R9 left enable off
    '{1'b0, 1'b1, 10'd5, 1'b0, 1'b1, 1'b1, 10'd5, 1'b1, 1'b1, 6'b010110}, // R2 left arrives late
    '{1'b0, 1'b1, 10'd5, 1'b0, 1'b1, 1'b1, 10'd6, 1'b1, 1'b1, 6'b110100}, // R9 address moves
    '{1'b0, 1'b0, 10'd0, 1'b0, 1'b1, 1'b0, 10'd0, 1'b0, 1'b1, 6'b110000}, // idle
    '{1'b0, 1'b1, 10'd9, 1'b1, 1'b1, 1'b1, 10'd9, 1'b1, 1'b1, 6'b101000}, // R4 same-cycle writes
    '{1'b0, 1'b1, 10'd9, 1'b1, 1'b1, 1'b1, 10'd9, 1'b1, 1'b1, 6'b101000}, // R2 decision held
    '{1'b0, 1'b0, 10'd0, 1'b0, 1'b1, 1'b0, 10'd0, 1'b0, 1'b1, 6'b110000}, // idle
    '{1'b0, 1'b1, 10'd3, 1'b0, 1'b1, 1'b1, 10'd3, 1'b0, 1'b1, 6'b100001}, // R5 same-cycle reads
    '{1'b0, 1'b0, 10'd0, 1'b0, 1'b1, 1'b0, 10'd0, 1'b0, 1'b1, 6'b110000}, // idle
    '{1'b0, 1'b1, 10'd1, 1'b1, 1'b1, 1'b1, 10'd2, 1'b1, 1'b1, 6'b111100}, // R1 different addresses
    '{1'b0, 1'b1, 10'd1, 1'b1, 1'b0, 1'b1, 10'd2, 1'b1, 1'b0, 6'b111100}, // R6 busy inputs ignored
    '{1'b1, 1'b1, 10'd7, 1'b1, 1'b0, 1'b1, 10'd7, 1'b1, 1'b1, 6'b110100}, // R7 slave inhibit left
    '{1'b1, 1'b1, 10'd7, 1'b0, 1'b0, 1'b1, 10'd8, 1'b1, 1'b0, 6'b110010}, // R7 R8 slave both inhibited
    '{1'b1, 1'b1, 10'd7, 1'b1, 1'b1, 1'b1, 10'd7, 1'b1, 1'b1, 6'b111100}, // R7 no arbitration
    '{1'b0, 1'b1, 10'd7, 1'b1, 1'b1, 1'b1, 10'd7, 1'b1, 1'b1, 6'b101000}, // R4 both held, left wins
    '{1'b0, 1'b0, 10'd0, 1'b0, 1'b1, 1'b0, 10'd0, 1'b0, 1'b1, 6'b110000}  // idle
  };

  localparam int VREQ [NVEC] = '{1, 1, 2, 6, 9, 2, 9, 1, 4, 2, 1, 5, 1, 1, 6, 7, 7, 7, 4, 1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slaveMode = 1'b0;
  logic leftEn = 1'b0, rightEn = 1'b0;
  logic [AW-1:0] leftAddr = '0, rightAddr = '0;
  logic leftWe = 1'b0, rightWe = 1'b0;
  logic leftBusyInN = 1'b1, rightBusyInN = 1'b1;
  logic leftBusyOutN, rightBusyOutN, leftWeGated, rightWeGated;
  logic leftRdSuspect, rightRdSuspect;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  dpbusy_arbiter #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .leftEn(leftEn), .leftAddr(leftAddr), .leftWe(leftWe), .leftBusyInN(leftBusyInN),
    .rightEn(rightEn), .rightAddr(rightAddr), .rightWe(rightWe), .rightBusyInN(rightBusyInN),
    .leftBusyOutN(leftBusyOutN), .rightBusyOutN(rightBusyOutN),
    .leftWeGated(leftWeGated), .rightWeGated(rightWeGated),
    .leftRdSuspect(leftRdSuspect), .rightRdSuspect(rightRdSuspect)
  );

  function automatic logic [5:0] observed();
    return {leftBusyOutN, rightBusyOutN, leftWeGated, rightWeGated,
            leftRdSuspect, rightRdSuspect};
  endfunction

  task automatic checkOut(input logic [5:0] expv, input string tag);
    logic [5:0] act;
    act = observed();
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s outputs actual=%b expected=%b", tag, act, expv);
    end
    checks++;
    if (act[5] === 1'b0 && act[4] === 1'b0) begin
      failures++;
      $display("FAIL R3 (%s) both busy low actual=%b expected=not both 0", tag, act[5:4]);
    end
  endtask

  task automatic drive(input vecT v);
    slaveMode    = v.slv;
    leftEn       = v.lEn;
    leftAddr     = v.lAddr;
    leftWe       = v.lWe;
    leftBusyInN  = v.lBin;
    rightEn      = v.rEn;
    rightAddr    = v.rAddr;
    rightWe      = v.rWe;
    rightBusyInN = v.rBin;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    vecT contend;
    string tag;
    contend = '{1'b0, 1'b1, 10'd4, 1'b1, 1'b1, 1'b1, 10'd4, 1'b1, 1'b1, 6'b000000};

    // R10: contention presented while in reset
    @(negedge clk);
    drive(contend);
    #5;
    checkOut(6'b110000, "R10");
    @(negedge clk);
    #5;
    checkOut(6'b110000, "R10");

    // R4: first cycle after reset, history cleared, right loses
    @(negedge clk);
    rstN = 1'b1;
    #5;
    checkOut(6'b101000, "R4");

    // R2: decision held on the next cycle
    @(negedge clk);
    #5;
    checkOut(6'b101000, "R2");

    // R9: right enable drops, busy released at once
    @(negedge clk);
    rightEn = 1'b0;
    #5;
    checkOut(6'b111000, "R9");

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #5;
      tag = $sformatf("R%0d (vector %0d)", VREQ[i], i);
      checkOut(VECS[i].expv, tag);
    end

    // R5: same-cycle contention with left write, right read, right still loses
    @(negedge clk);
    drive('{1'b0, 1'b1, 10'd12, 1'b1, 1'b1, 1'b1, 10'd12, 1'b0, 1'b1, 6'b0});
    #5;
    checkOut(6'b101001, "R5");

    // R8: a read on the winning port is not suspect
    @(negedge clk);
    leftWe = 1'b0;
    #5;
    checkOut(6'b100001, "R8");

    // R10: reset in the middle of contention
    @(negedge clk);
    rstN = 1'b0;
    #5;
    checkOut(6'b110000, "R10");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog (R1 to R10 run) actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule